// File: doc/BRIEF.md
# Single-Cycle Subset Integer Core

This block is a 32-bit processor that completes one instruction per clock. Each cycle it presents a word address to an instruction port, decodes the returned word, and reads two operands from a 32-entry register file. It then computes a result and, within the same cycle, either writes a register, stores a word to the data port or loads one from it, and moves the program counter. It understands three encodings: a register-to-register form, a 16-bit immediate form and a 26-bit jump form.

The supported operations are a deliberately small set:
- add, subtract, unsigned set-less-than and left shift between registers;
- add-immediate, upper-immediate and or-immediate;
- word load and word store;
- equal and not-equal branches;
- absolute jump, jump-and-link and jump-through-register.

Any other operation or function code sets a sticky flag and leaves the register file and the data memory untouched. The clock is a single domain. The active-low reset is asserted asynchronously and released through a two-stage synchronizer.

The instruction port is word addressed and read combinationally. The data port works as follows:
- a load returns its data within the same cycle;
- a store is committed at the rising edge while the write enable is high.

Top module: `rcore_top`

## Requirements
- R1: While reset is held, and for the cycles the synchronizer takes to release it, the PC is 0, so `imem_addr` is 0. `illegal` is low. The first instruction executed is the one at word 0.
- R2: Register-form fields run from the MSB down: op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]. With op=0, the funct codes select:
  - funct 33: rd = rs + rt, modulo 2^32;
  - funct 35: rd = rs - rt, modulo 2^32;
  - funct 43: rd = 1 if rs < rt as unsigned values, else 0.
- R3: With op=0 and funct=0, rd = rt shifted left by shamt. The all-zero word is therefore a no-op that changes no register and no memory.
- R4: Immediate-form fields are op[31:26], rs[25:21], rt[20:16] and imm[15:0], and rt is the destination.
  - op 9: rt = rs + sign-extended imm.
  - op 15: rt = {imm, 16'h0}.
  - op 13: rt = rs OR zero-extended imm.
- R5: Load (op 35) and store (op 43) form a byte address as rs + sign-extended imm. `dmem_addr` is bits [DMEM_AW+1:2] of that sum.
  - A load writes `dmem_rdata` to rt.
  - A store drives rt on `dmem_wdata` with `dmem_we` high for that one cycle.
- R6: Branch-if-equal (op 4) and branch-if-not-equal (op 5) compare rs with rt.
  - When taken, PC = PC + 4 + (sign-extended imm × 4). A negative imm branches backwards.
  - Every instruction that neither branches taken nor jumps moves the PC by 4.
- R7: Jump (op 2) and jump-and-link (op 3) set PC = {(PC+4)[31:28], addr[25:0], 2'b00}. Jump-and-link also writes PC+4 into register 31.
- R8: With op=0 and funct=8, PC = rs, and no register is written.
- R9: Register 0 always reads as zero, and any write addressed to it is discarded.
- R10: An op outside {0,2,3,4,5,9,13,15,35,43}, or op=0 with a funct outside {0,8,33,35,43}, behaves as follows:
  - it writes no register and drives no store;
  - the PC advances by 4;
  - `illegal` goes high from the next cycle and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | IMEM_AW | Word address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | DMEM_AW | Word address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| illegal | output | 1 | Sticky flag: an unsupported encoding was executed |

## Verification
The hardest situations to reach from the ports are these:
- a link value arriving in register 31;
- a branch that turns backward;
- a write to register 0 that must vanish.

None of them is visible unless a later store exposes the register. The program is therefore arranged so that every interesting result is written to data memory, and a scoreboard compares each store against a precomputed address and value.

Control flow is proven by the order and count of the stores, because a wrong PC produces an extra, missing or reordered store:
- a jump-and-link followed by a jump-through-register return;
- a two-pass countdown loop on a negative branch offset.

The unsupported encodings are placed just after a register has been loaded with a known value, and that register is then stored. This shows that neither encoding disturbed it.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam int XLEN     = 32;
  localparam int NREG     = 32;
  localparam int RAW      = $clog2(NREG);
  localparam int LINK_REG = NREG - 1;

  // primary opcodes
  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JMP   = 6'd2;
  localparam logic [5:0] OPC_JAL   = 6'd3;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_BNE   = 6'd5;
  localparam logic [5:0] OPC_ADDI  = 6'd9;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_UPPER = 6'd15;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  // function codes under OPC_REG
  localparam logic [5:0] FN_SHL  = 6'd0;
  localparam logic [5:0] FN_JREG = 6'd8;
  localparam logic [5:0] FN_ADD  = 6'd33;
  localparam logic [5:0] FN_SUB  = 6'd35;
  localparam logic [5:0] FN_LTU  = 6'd43;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_LTU, ALU_SHL, ALU_OR, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG, OPB_SEXT, OPB_ZEXT, OPB_UPPER
  } opb_sel_e;

  typedef enum logic [1:0] {
    DST_RD, DST_RT, DST_LINK
  } dst_sel_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_MEM, WB_LINK
  } wb_sel_e;

  typedef enum logic [2:0] {
    NPC_SEQ, NPC_BEQ, NPC_BNE, NPC_JUMP, NPC_JREG
  } npc_sel_e;

  typedef struct packed {
    logic     rf_we;
    dst_sel_e dst;
    alu_op_e  alu_op;
    opb_sel_e opb;
    logic     mem_we;
    wb_sel_e  wb;
    npc_sel_e npc;
    logic     bad;
  } ctrl_t;

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.dst    = DST_RT;
    ctrl.alu_op = ALU_ADD;
    ctrl.opb    = OPB_REG;
    ctrl.wb     = WB_ALU;
    ctrl.npc    = NPC_SEQ;
    unique case (opc)
      OPC_REG: begin
        ctrl.dst = DST_RD;
        unique case (fn)
          FN_ADD:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_LTU:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_LTU; end
          FN_SHL:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SHL; end
          FN_JREG: ctrl.npc = NPC_JREG;
          default: ctrl.bad = 1'b1;
        endcase
      end
      OPC_ADDI: begin
        ctrl.rf_we = 1'b1; ctrl.opb = OPB_SEXT;
      end
      OPC_ORI: begin
        ctrl.rf_we = 1'b1; ctrl.opb = OPB_ZEXT; ctrl.alu_op = ALU_OR;
      end
      OPC_UPPER: begin
        ctrl.rf_we = 1'b1; ctrl.opb = OPB_UPPER; ctrl.alu_op = ALU_PASSB;
      end
      OPC_LOAD: begin
        ctrl.rf_we = 1'b1; ctrl.opb = OPB_SEXT; ctrl.wb = WB_MEM;
      end
      OPC_STORE: begin
        ctrl.mem_we = 1'b1; ctrl.opb = OPB_SEXT;
      end
      OPC_BEQ:  ctrl.npc = NPC_BEQ;
      OPC_BNE:  ctrl.npc = NPC_BNE;
      OPC_JMP:  ctrl.npc = NPC_JUMP;
      OPC_JAL: begin
        ctrl.npc = NPC_JUMP; ctrl.rf_we = 1'b1;
        ctrl.dst = DST_LINK; ctrl.wb = WB_LINK;
      end
      default: ctrl.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile
  import rcore_pkg::*;
(
  input  logic            clk,
  input  logic [RAW-1:0]  raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [RAW-1:0]  raddr_b,
  output logic [XLEN-1:0] rdata_b,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata
);

  // entry 0 has no storage: it is the constant zero
  logic [XLEN-1:0] regs [1:NREG-1];
  logic [NREG-1:1] wen;

  for (genvar g = 1; g < NREG; g++) begin : g_wen
    assign wen[g] = we && (waddr == RAW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 1; i < NREG; i++) begin
      if (wen[i]) regs[i] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [4:0]      shamt,
  output logic [XLEN-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_LTU:   y = {{(XLEN-1){1'b0}}, (a < b)};
      ALU_SHL:   y = b << shamt;
      ALU_OR:    y = a | b;
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end

  always_comb begin
    if (op == ALU_LTU) begin
      AST_LTU_IS_BOOL: assert (y[XLEN-1:1] == '0); // R2
    end
  end

endmodule

// File: rtl/rcore_nextpc.sv
module rcore_nextpc
  import rcore_pkg::*;
(
  input  npc_sel_e        sel,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [15:0]     imm,
  input  logic [25:0]     jidx,
  output logic [XLEN-1:0] pc_plus4,
  output logic [XLEN-1:0] pc_next
);

  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic            same;

  assign pc_plus4   = pc + XLEN'(4);
  assign br_target  = pc_plus4 + {{(XLEN-18){imm[15]}}, imm, 2'b00};
  assign jmp_target = {pc_plus4[XLEN-1:28], jidx, 2'b00};
  assign same       = (rs_val == rt_val);

  always_comb begin
    unique case (sel)
      NPC_BEQ:  pc_next = same  ? br_target : pc_plus4;
      NPC_BNE:  pc_next = !same ? br_target : pc_plus4;
      NPC_JUMP: pc_next = jmp_target;
      NPC_JREG: pc_next = rs_val;
      default:  pc_next = pc_plus4;
    endcase
  end

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int IMEM_AW = 10,
  parameter int DMEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [XLEN-1:0]    imem_data,
  output logic [DMEM_AW-1:0] dmem_addr,
  output logic [XLEN-1:0]    dmem_wdata,
  output logic               dmem_we,
  input  logic [XLEN-1:0]    dmem_rdata,
  output logic               illegal
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // instruction fields
  logic [5:0]      f_op, f_fn;
  logic [RAW-1:0]  f_rs, f_rt, f_rd;
  logic [4:0]      f_sh;
  logic [15:0]     f_imm;
  logic [25:0]     f_jidx;

  assign f_op   = imem_data[31:26];
  assign f_rs   = imem_data[25:21];
  assign f_rt   = imem_data[20:16];
  assign f_rd   = imem_data[15:11];
  assign f_sh   = imem_data[10:6];
  assign f_fn   = imem_data[5:0];
  assign f_imm  = imem_data[15:0];
  assign f_jidx = imem_data[25:0];

  ctrl_t ctrl;

  rcore_decode u_decode (
    .opc  (f_op),
    .fn   (f_fn),
    .ctrl (ctrl)
  );

  // register file
  logic [XLEN-1:0] rs_val, rt_val, rf_wdata;
  logic [RAW-1:0]  rf_waddr;
  logic            rf_we;

  rcore_regfile u_rf (
    .clk     (clk),
    .raddr_a (f_rs),
    .rdata_a (rs_val),
    .raddr_b (f_rt),
    .rdata_b (rt_val),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata)
  );

  // operand B and ALU
  logic [XLEN-1:0] simm, opb, alu_y;

  assign simm = {{(XLEN-16){f_imm[15]}}, f_imm};

  always_comb begin
    unique case (ctrl.opb)
      OPB_SEXT:  opb = simm;
      OPB_ZEXT:  opb = {{(XLEN-16){1'b0}}, f_imm};
      OPB_UPPER: opb = {f_imm, {(XLEN-16){1'b0}}};
      default:   opb = rt_val;
    endcase
  end

  rcore_alu u_alu (
    .op    (ctrl.alu_op),
    .a     (rs_val),
    .b     (opb),
    .shamt (f_sh),
    .y     (alu_y)
  );

  // program counter
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4;
  logic            pc_en;

  rcore_nextpc u_npc (
    .sel      (ctrl.npc),
    .pc       (pc_q),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .imm      (f_imm),
    .jidx     (f_jidx),
    .pc_plus4 (pc_plus4),
    .pc_next  (pc_d)
  );

  assign pc_en = 1'b1;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  pc_q <= '0;
    else if (pc_en)   pc_q <= pc_d;
  end

  assign imem_addr = pc_q[IMEM_AW+1:2];

  // write-back
  always_comb begin
    unique case (ctrl.dst)
      DST_RD:   rf_waddr = f_rd;
      DST_LINK: rf_waddr = RAW'(LINK_REG);
      default:  rf_waddr = f_rt;
    endcase
    unique case (ctrl.wb)
      WB_MEM:  rf_wdata = dmem_rdata;
      WB_LINK: rf_wdata = pc_plus4;
      default: rf_wdata = alu_y;
    endcase
  end

  assign rf_we = ctrl.rf_we && rst_core_n;

  // data port
  assign dmem_addr  = alu_y[DMEM_AW+1:2];
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we && rst_core_n;

  // sticky unsupported-encoding flag
  logic bad_q, bad_d, bad_en;

  assign bad_en = ctrl.bad;
  assign bad_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  bad_q <= 1'b0;
    else if (bad_en)  bad_q <= bad_d;
  end

  assign illegal = bad_q;

  // checks
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctrl.npc == NPC_SEQ) |=> (pc_q == $past(pc_q) + 32'd4)); // R6

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctrl.npc == NPC_BEQ && rs_val == rt_val)
      |=> (pc_q == $past(pc_q) + 32'd4 + {$past(simm[29:0]), 2'b00})); // R6

  AST_LINK_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (f_op == OPC_JAL) |-> (rf_we && rf_waddr == RAW'(LINK_REG)
                           && rf_wdata == pc_q + 32'd4)); // R7

  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ctrl.bad |-> (!rf_we && !dmem_we)); // R10

  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    bad_q |=> bad_q); // R10

  AST_BAD_SETS: assert property (@(posedge clk) disable iff (!rst_core_n)
    ctrl.bad |=> bad_q); // R10

endmodule

// File: tb/rcore_top_tb.sv
module rcore_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IAW = 10;
  localparam int DAW = 10;
  localparam int END_WORD = 55;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [IAW-1:0] imem_addr;
  logic [31:0]    imem_data;
  logic [DAW-1:0] dmem_addr;
  logic [31:0]    dmem_wdata;
  logic           dmem_we;
  logic [31:0]    dmem_rdata;
  logic           illegal;

  logic [31:0] imem [1 << IAW];
  logic [31:0] dmem [1 << DAW];

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    int unsigned waddr;
    logic [31:0] data;
    string       tag;
  } store_t;

  store_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rcore_top #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .illegal    (illegal)
  );

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  // encoders
  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int op, int idx);
    return {op[5:0], idx[25:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic expect_store(int unsigned wa, logic [31:0] d, string tag);
    store_t s;
    s.waddr = wa; s.data = d; s.tag = tag;
    exp_q.push_back(s);
  endtask

  // monitor: compare each store against the scoreboard
  always @(negedge clk) begin
    if (rst_n && dmem_we) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL unexpected store: actual addr %0d data 0x%08h expected none",
                 dmem_addr, dmem_wdata);
      end else begin
        store_t s;
        s = exp_q.pop_front();
        check({s.tag, " addr"}, 32'(dmem_addr), 32'(s.waddr));
        check({s.tag, " data"}, dmem_wdata, s.data);
      end
    end
  end

  task automatic wait_word(int w, int limit, output bit ok);
    ok = 1'b0;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (imem_addr == IAW'(w)) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual never reached expected word %0d", w);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < (1 << IAW); i++) imem[i] = 32'h0;
    for (int i = 0; i < (1 << DAW); i++) dmem[i] = 32'h0;
    imem[0]  = enc_i(9, 0, 1, 5);                 // r1 = 5
    imem[1]  = enc_i(9, 0, 2, -3);                // r2 = -3
    imem[2]  = enc_r(1, 2, 3, 0, 33);             // r3 = r1 + r2
    imem[3]  = enc_i(43, 0, 3, 'h100);
    imem[4]  = enc_r(1, 2, 4, 0, 35);             // r4 = r1 - r2
    imem[5]  = enc_i(43, 0, 4, 'h104);
    imem[6]  = enc_r(1, 2, 5, 0, 43);             // 5 <u 0xFFFFFFFD
    imem[7]  = enc_r(2, 1, 6, 0, 43);
    imem[8]  = enc_i(43, 0, 5, 'h108);
    imem[9]  = enc_i(43, 0, 6, 'h10C);
    imem[10] = enc_r(0, 1, 7, 4, 0);              // r7 = r1 << 4
    imem[11] = enc_i(43, 0, 7, 'h110);
    imem[12] = enc_i(15, 0, 8, 'h1234);           // upper
    imem[13] = enc_i(13, 8, 8, 'h8765);           // or, zero-extended
    imem[14] = enc_i(43, 0, 8, 'h114);
    imem[15] = enc_i(9, 1, 0, 7);                 // write to r0
    imem[16] = enc_i(43, 0, 0, 'h118);
    imem[17] = enc_i(35, 0, 9, 'h114);            // load back
    imem[18] = enc_i(9, 9, 9, 1);
    imem[19] = enc_i(43, 0, 9, 'h11C);
    imem[20] = enc_i(9, 0, 10, 'h128);
    imem[21] = enc_i(35, 10, 11, -20);            // negative offset
    imem[22] = enc_i(43, 10, 11, 4);
    imem[23] = enc_i(4, 1, 2, 1);                 // beq not taken
    imem[24] = enc_i(9, 0, 12, 'h11);
    imem[25] = enc_i(5, 1, 2, 1);                 // bne taken
    imem[26] = enc_i(9, 0, 12, 'h99);
    imem[27] = enc_i(43, 0, 12, 'h130);
    imem[28] = enc_i(4, 1, 1, 1);                 // beq taken
    imem[29] = enc_i(9, 0, 12, 'h77);
    imem[30] = enc_i(5, 1, 1, 1);                 // bne not taken
    imem[31] = enc_i(9, 0, 13, 'h22);
    imem[32] = enc_i(43, 0, 12, 'h134);
    imem[33] = enc_i(43, 0, 13, 'h138);
    imem[34] = enc_j(3, 40);                      // call
    imem[35] = enc_i(43, 0, 14, 'h140);
    imem[36] = enc_i(43, 0, 31, 'h13C);
    imem[37] = enc_j(2, 45);
    imem[40] = enc_i(9, 0, 14, 'h55);
    imem[41] = enc_r(31, 0, 0, 0, 8);             // return through r31
    imem[45] = enc_i(9, 0, 15, 2);
    imem[46] = enc_i(9, 15, 15, -1);
    imem[47] = enc_i(5, 15, 0, -2);               // backward loop
    imem[48] = enc_i(43, 0, 15, 'h144);
    imem[49] = enc_i(9, 0, 16, 'h66);
    imem[50] = enc_r(1, 1, 16, 0, 32);            // unsupported funct
    imem[51] = {6'h3F, 5'd1, 5'd16, 16'h0001};    // unsupported op
    imem[52] = enc_i(43, 0, 16, 'h148);
    imem[53] = 32'h0000_0000;                     // no-op
    imem[54] = enc_i(43, 0, 1, 'h14C);
    imem[55] = enc_j(2, 55);                      // spin
  endtask

  task automatic load_expectations();
    expect_store(64, 32'd2,         "R2 add");
    expect_store(65, 32'd8,         "R2 sub");
    expect_store(66, 32'd1,         "R2 ltu true");
    expect_store(67, 32'd0,         "R2 ltu false");
    expect_store(68, 32'd80,        "R3 shift");
    expect_store(69, 32'h1234_8765, "R4 upper+or");
    expect_store(70, 32'd0,         "R9 zero reg");
    expect_store(71, 32'h1234_8766, "R5 load");
    expect_store(75, 32'h1234_8765, "R5 neg offset");
    expect_store(76, 32'h11,        "R6 beq/bne");
    expect_store(77, 32'h11,        "R6 beq taken");
    expect_store(78, 32'h22,        "R6 bne fallthrough");
    expect_store(80, 32'h55,        "R8 return");
    expect_store(79, 32'd140,       "R7 link");
    expect_store(81, 32'd0,         "R6 backward loop");
    expect_store(82, 32'h66,        "R10 no write");
    expect_store(83, 32'd5,         "R3 nop");
  endtask

  initial begin
    bit ok;
    load_program();
    load_expectations();
    repeat (3) @(negedge clk);
    check("R1 reset pc", 32'(imem_addr), 32'd0);
    check("R1 reset flag", 32'(illegal), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pc after release", 32'(imem_addr), 32'd0);
    check("R1 no store after release", 32'(dmem_we), 32'd0);
    wait_word(50, 2000, ok);
    if (ok) check("R10 flag clear before", 32'(illegal), 32'd0);
    wait_word(52, 20, ok);
    if (ok) check("R10 flag raised", 32'(illegal), 32'd1);
    wait_word(END_WORD, 200, ok);
    repeat (3) @(negedge clk);
    check("R10 flag sticky", 32'(illegal), 32'd1);
    check("R7 all stores seen", 32'(exp_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule